// File: doc/BRIEF.md
# Weight-Stationary Integer Matrix Multiply Array

This block is a square grid of N by N signed 8-bit multiply-accumulate cells that multiplies a stream of input vectors by a weight tile held inside the grid. The tile arrives one row per beat over a valid/ready weight port and lands first in a shadow copy. It becomes the active tile only when no batch is in flight, so one batch never mixes two tiles. Loading the next tile can therefore overlap the current batch.

A batch is any number B of input rows, one row per clock, marked by a last flag on its final row. Row values are skewed one cycle per grid row, and partial sums travel down the columns. Column outputs are then deskewed, so each result row leaves the grid as a whole N-lane vector of 32-bit sums. Each result row is written into an internal accumulator bank at consecutive addresses starting from a base given with the first row. The write either replaces the stored entry or adds to it. A single read port returns stored entries. Reads take priority over result writes, and a read that collides with a pending result freezes the whole grid. A one-cycle done pulse follows the write of each batch's last row.

Top module: `wsmm_array`

## Requirements
- R1: After reset, in_ready and w_ready are high, done is low, and the active tile is all zero, so a batch run before any tile load stores zero in every lane.
- R2: Result lane j (rd_data bits 32j+31:32j) equals the sum over i of x_i times W[i][j], in 32-bit two's complement. Here x_i is in_row bits 8i+7:8i (signed), W row i is the i-th weight beat of the tile, and W[i][j] is bits 8j+7:8j of that beat (signed).
- R3: With no read collisions, done goes high after the 2N-1-th rising edge that follows the edge accepting a batch's last row.
- R4: Within a batch, with no read and no full tile waiting, in_ready stays high, so one row is accepted every cycle.
- R5: Row k of a batch is written to entry (base + k) modulo ACC_DEPTH, where base is in_base sampled with the batch's first row. ACC_DEPTH is a power of two.
- R6: in_accum, sampled with the first row, selects for the whole batch between overwrite (0) and add to the stored entry (1). Entries outside the batch keep their values.
- R7: w_ready stays high until N weight beats have been taken. It then stays low until that tile has been made active.
- R8: A completed shadow tile becomes active only when no batch is in flight. A batch in flight keeps the tile it started with, and the next batch uses the new tile.
- R9: A read (rd_en) returns entry rd_addr on rd_data on the next cycle. While a result row waits and rd_en is high, the grid freezes, in_ready is low, and no result is lost or changed.
- R10: done is high for exactly one cycle per batch, right after the write of that batch's last row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| w_valid | input | 1 | Weight beat offered |
| w_ready | output | 1 | Shadow tile can take a beat |
| w_row | input | N*8 | One tile row, lane j at bits 8j+7:8j |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Input row accepted this cycle when valid |
| in_row | input | N*8 | Input vector, element i at bits 8i+7:8i |
| in_accum | input | 1 | Add (1) or overwrite (0); used on first row |
| in_base | input | log2(ACC_DEPTH) | Start entry; used on first row |
| in_last | input | 1 | Marks the batch's final row |
| rd_en | input | 1 | Read the accumulator bank |
| rd_addr | input | log2(ACC_DEPTH) | Entry to read |
| rd_data | output | N*32 | Entry read, lane j at bits 32j+31:32j |
| done | output | 1 | One-cycle pulse after a batch's last write |

## Verification
The bench drives both sign extremes (-128 against -128 and 127 against -128) to catch a product or sum that is truncated or zero-extended. Such an error shows up as a wrong lane sign or magnitude. A batch that runs past the top of the bank checks address wrap, where a faulty counter writes beyond the last entry or misses entry 0. A new tile is loaded while a long batch streams, which exposes a swap taken too early: the batch would then hold rows computed with the new weights. A long read collision with a result waiting catches a grid that keeps moving or drops the pending row. That would appear as a done pulse during the stall or a stale entry afterward.

// File: rtl/wsmm_pkg.sv
package wsmm_pkg;
  localparam int OPND_W = 8;
  localparam int PROD_W = 2 * OPND_W;
  localparam int SUM_W  = 32;

  typedef logic signed [OPND_W-1:0] opnd_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [SUM_W-1:0]  sum_t;
endpackage

// File: rtl/wsmm_delay.sv
// Enable-gated delay chain; zero stages degenerates to a wire.
module wsmm_delay #(
  parameter int STAGES = 1,
  parameter int W      = 8
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_wire
      logic unused_pins;
      assign unused_pins = clk ^ en;
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (en) begin
          stg[0] <= d;
          for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wsmm_cell.sv
// One multiply-accumulate cell: passes its operand right, its sum down.
module wsmm_cell
  import wsmm_pkg::*;
(
  input  logic  clk,
  input  logic  en,
  input  opnd_t a_in,
  input  opnd_t w,
  input  sum_t  ps_in,
  output opnd_t a_out,
  output sum_t  ps_out
);
  prod_t prod;
  sum_t  ps_next;

  always_comb begin
    prod    = a_in * w;
    ps_next = ps_in + sum_t'(prod);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      a_out  <= a_in;
      ps_out <= ps_next;
    end
  end
endmodule

// File: rtl/wsmm_accbank.sv
// Result storage: one write port with optional add, one read port.
module wsmm_accbank
  import wsmm_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int ENTRIES = 16,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_accum,
  input  logic [AW-1:0]          wr_addr,
  input  logic [LANES*SUM_W-1:0] wr_data,
  input  logic                   rd_en,
  input  logic [AW-1:0]          rd_addr,
  output logic [LANES*SUM_W-1:0] rd_data
);
  logic [LANES*SUM_W-1:0] mem [ENTRIES];
  logic [LANES*SUM_W-1:0] merged;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      merged[l*SUM_W +: SUM_W] = wr_accum
        ? mem[wr_addr][l*SUM_W +: SUM_W] + wr_data[l*SUM_W +: SUM_W]
        : wr_data[l*SUM_W +: SUM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !wr_en) else $error("read and write collided"); // R9
endmodule

// File: rtl/wsmm_array.sv
module wsmm_array
  import wsmm_pkg::*;
#(
  parameter int N         = 8,
  parameter int ACC_DEPTH = 16,
  localparam int AW       = $clog2(ACC_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               w_valid,
  output logic               w_ready,
  input  logic [N*OPND_W-1:0] w_row,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [N*OPND_W-1:0] in_row,
  input  logic               in_accum,
  input  logic [AW-1:0]      in_base,
  input  logic               in_last,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [N*SUM_W-1:0] rd_data,
  output logic               done
);
  localparam int PIPE = 2 * N - 1;
  localparam int RW   = (N > 1) ? $clog2(N) : 1;

  typedef struct packed {
    logic          v;
    logic          last;
    logic          accum;
    logic [AW-1:0] addr;
  } tag_t;

  logic [N-1:0][N-1:0][OPND_W-1:0] w_shadow, w_act;
  logic [RW-1:0] row_q, row_d;
  logic          full_q, full_d;
  logic          mid_q, mid_d, acc_q, acc_d, done_d;
  logic [AW-1:0] addr_q, addr_d;
  tag_t          tag_q [PIPE];
  tag_t          tag_in, tag_out;
  logic          adv, accept, w_take, swap, busy, wr_en;
  logic [N*SUM_W-1:0] res;

  // control next state
  always_comb begin
    tag_out  = tag_q[PIPE-1];
    busy     = mid_q;
    for (int k = 0; k < PIPE; k++) busy = busy | tag_q[k].v;
    adv      = !(tag_out.v && rd_en);
    wr_en    = tag_out.v && !rd_en;
    in_ready = adv && (mid_q || !full_q);
    accept   = in_valid && in_ready;
    w_ready  = !full_q;
    w_take   = w_valid && w_ready;
    swap     = full_q && !busy;

    row_d  = row_q;
    full_d = full_q;
    if (w_take) begin
      if (row_q == RW'(N - 1)) begin
        row_d  = '0;
        full_d = 1'b1;
      end else begin
        row_d = row_q + 1'b1;
      end
    end
    if (swap) full_d = 1'b0;

    tag_in.v     = accept;
    tag_in.last  = in_last;
    tag_in.accum = mid_q ? acc_q  : in_accum;
    tag_in.addr  = mid_q ? addr_q : in_base;
    mid_d  = accept ? !in_last         : mid_q;
    acc_d  = accept ? tag_in.accum     : acc_q;
    addr_d = accept ? tag_in.addr + 1'b1 : addr_q;
    done_d = wr_en && tag_out.last;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      full_q <= 1'b0;
      mid_q  <= 1'b0;
      acc_q  <= 1'b0;
      addr_q <= '0;
      done   <= 1'b0;
      w_act  <= '0;
      for (int k = 0; k < PIPE; k++) tag_q[k] <= '0;
    end else begin
      row_q  <= row_d;
      full_q <= full_d;
      mid_q  <= mid_d;
      acc_q  <= acc_d;
      addr_q <= addr_d;
      done   <= done_d;
      if (swap) w_act <= w_shadow;
      if (adv) begin
        tag_q[0] <= tag_in;
        for (int k = 1; k < PIPE; k++) tag_q[k] <= tag_q[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (w_take) w_shadow[row_q] <= w_row;
  end

  // systolic grid
  opnd_t a_bus  [N][N+1];
  sum_t  ps_bus [N+1][N];
  logic  unused_edge;

  always_comb begin
    unused_edge = 1'b0;
    for (int i = 0; i < N; i++) unused_edge = unused_edge ^ (^a_bus[i][N]);
  end

  genvar gi, gj;
  generate
    for (gi = 0; gi < N; gi++) begin : g_row
      wsmm_delay #(.STAGES(gi), .W(OPND_W)) u_skew (
        .clk(clk), .en(adv), .d(in_row[gi*OPND_W +: OPND_W]), .q(a_bus[gi][0]));
      for (gj = 0; gj < N; gj++) begin : g_col
        wsmm_cell u_cell (
          .clk(clk), .en(adv), .a_in(a_bus[gi][gj]), .w(w_act[gi][gj]),
          .ps_in(ps_bus[gi][gj]), .a_out(a_bus[gi][gj+1]), .ps_out(ps_bus[gi+1][gj]));
      end
    end
    for (gj = 0; gj < N; gj++) begin : g_out
      assign ps_bus[0][gj] = '0;
      wsmm_delay #(.STAGES(N-1-gj), .W(SUM_W)) u_deskew (
        .clk(clk), .en(adv), .d(ps_bus[N][gj]), .q(res[gj*SUM_W +: SUM_W]));
    end
  endgenerate

  wsmm_accbank #(.LANES(N), .ENTRIES(ACC_DEPTH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_accum(tag_out.accum),
    .wr_addr(tag_out.addr), .wr_data(res), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data));

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_out.v && rd_en) |-> !in_ready) else $error("input taken during stall"); // R9
  AST_TILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(w_act)) else $error("tile changed mid batch"); // R8
  AST_SHADOW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (w_take && row_q == RW'(N - 1)) |=> !w_ready) else $error("full tile still open"); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && !$past(tag_out.last))
      |-> tag_out.addr == AW'($past(tag_out.addr) + 1'b1)) else $error("address skipped"); // R5
endmodule

// File: tb/wsmm_array_test.sv
module wsmm_array_test;
  localparam int N = 8, DEPTH = 16, AW = 4, LAT = 2 * N - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, w_valid, w_ready, in_valid, in_ready, in_accum, in_last, rd_en, done;
  logic [N*8-1:0]  w_row, in_row;
  logic [AW-1:0]   in_base, rd_addr;
  logic [N*32-1:0] rd_data;

  wsmm_array #(.N(N), .ACC_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .w_ready(w_ready), .w_row(w_row),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row), .in_accum(in_accum),
    .in_base(in_base), .in_last(in_last), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done));

  int checks = 0, errors = 0;
  logic signed [7:0] mw [N][N];
  logic signed [7:0] nw [N][N];
  logic signed [7:0] xr [32][N];
  logic [31:0]       mb [DEPTH][N];

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input string what,
                         input logic [N*32-1:0] act, input logic [N*32-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [N*32-1:0] exp_entry(input int a);
    logic [N*32-1:0] v;
    for (int j = 0; j < N; j++) v[j*32 +: 32] = mb[a][j];
    return v;
  endfunction

  function automatic logic [N*8-1:0] pack_x(input int k);
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = xr[k][i];
    return v;
  endfunction

  task automatic model_apply(input int len, input int base, input bit acc);
    for (int k = 0; k < len; k++) begin
      int a;
      a = (base + k) % DEPTH;
      for (int j = 0; j < N; j++) begin
        int s;
        s = 0;
        for (int i = 0; i < N; i++) s += int'(xr[k][i]) * int'(mw[i][j]);
        mb[a][j] = acc ? mb[a][j] + 32'(s) : 32'(s);
      end
    end
  endtask

  task automatic rand_rows(input int len);
    for (int k = 0; k < len; k++)
      for (int i = 0; i < N; i++) xr[k][i] = 8'($urandom);
  endtask

  task automatic rand_tile();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) nw[r][c] = 8'($urandom);
  endtask

  task automatic load_tile();
    for (int r = 0; r < N; r++) begin
      bit got;
      do begin
        @(negedge clk);
        w_valid = 1'b1;
        for (int c = 0; c < N; c++) w_row[c*8 +: 8] = nw[r][c];
        #1 got = w_ready;
        @(posedge clk);
      end while (!got);
    end
    @(negedge clk);
    w_valid = 1'b0;
  endtask

  task automatic adopt_tile();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) mw[r][c] = nw[r][c];
  endtask

  task automatic rd_check(input int a, input string req);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk_vec(req, $sformatf("entry %0d", a), rd_data, exp_entry(a));
  endtask

  // streams xr[0..len-1]; checks R3 latency and, without gaps, R4
  task automatic run_batch(input int len, input int base, input bit acc, input int gap_pct);
    int k, lat;
    bit ok, ready_ok;
    k = 0;
    ready_ok = 1'b1;
    while (k < len) begin
      @(negedge clk);
      if (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        ok = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_row   = pack_x(k);
        in_last  = (k == len - 1);
        in_accum = acc;
        in_base  = AW'(base);
        #1 ok = in_ready;
        if (!ok) ready_ok = 1'b0;
      end
      @(posedge clk);
      if (ok) k++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    chk_int("R3", "edges from last accept to done", lat, LAT);
    if (gap_pct == 0) chk_int("R4", "in_ready held through batch", int'(ready_ok), 1);
    model_apply(len, base, acc);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R3: actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; w_valid = 1'b0; in_valid = 1'b0; in_accum = 1'b0; in_last = 1'b0;
    rd_en = 1'b0; w_row = '0; in_row = '0; in_base = '0; rd_addr = '0;
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) mw[r][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_int("R1", "in_ready after reset", int'(in_ready), 1);
    chk_int("R1", "w_ready after reset", int'(w_ready), 1);
    chk_int("R1", "done after reset", int'(done), 0);

    // R1: zero tile fills the whole bank with zeros
    rand_rows(16);
    run_batch(16, 0, 1'b0, 0);
    for (int a = 0; a < DEPTH; a++) rd_check(a, "R1");

    // R2: sign extremes
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) nw[r][c] = -8'sd128;
    load_tile(); adopt_tile(); @(negedge clk);
    for (int i = 0; i < N; i++) begin xr[0][i] = -8'sd128; xr[1][i] = 8'sd127; end
    run_batch(2, 4, 1'b0, 0);
    rd_check(4, "R2");
    rd_check(5, "R2");
    chk_int("R2", "lane 0 extreme value", int'($signed(rd_data[31:0])), -130048);

    // R5: wrap past the top of the bank
    rand_tile(); load_tile(); adopt_tile(); @(negedge clk);
    rand_rows(5);
    run_batch(5, 14, 1'b0, 0);
    for (int k = 0; k < 5; k++) rd_check((14 + k) % DEPTH, "R5");

    // R6: accumulate with gaps, neighbour untouched
    rand_rows(3);
    run_batch(3, 15, 1'b1, 30);
    rd_check(15, "R6"); rd_check(0, "R6"); rd_check(1, "R6"); rd_check(2, "R6");

    // R9: long read collision with a result waiting
    begin
      bit saw;
      int lat;
      rand_rows(1);
      @(negedge clk);
      in_valid = 1'b1; in_row = pack_x(0); in_last = 1'b1; in_accum = 1'b0; in_base = 4'd7;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      rd_en = 1'b1; rd_addr = 4'd14;
      saw = 1'b0;
      repeat (30) begin @(negedge clk); if (done) saw = 1'b1; end
      chk_int("R9", "in_ready while frozen", int'(in_ready), 0);
      chk_int("R9", "done during freeze", int'(saw), 0);
      chk_vec("R9", "read priority data", rd_data, exp_entry(14));
      rd_en = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin @(negedge clk); lat++; end
      chk_int("R9", "done after release", int'(done), 1);
      @(negedge clk);
      chk_int("R10", "done width one cycle", int'(done), 0);
      model_apply(1, 7, 1'b0);
      rd_check(7, "R9");
    end

    // R7/R8: load next tile while a long batch streams
    rand_tile();
    rand_rows(12);
    fork
      run_batch(12, 2, 1'b0, 0);
      begin
        repeat (3) @(negedge clk);
        load_tile();
        chk_int("R7", "w_ready with full tile waiting", int'(w_ready), 0);
      end
    join
    for (int k = 0; k < 12; k++) rd_check(2 + k, "R8");
    chk_int("R7", "w_ready after swap", int'(w_ready), 1);
    adopt_tile();
    rand_rows(3);
    run_batch(3, 0, 1'b0, 0);
    for (int k = 0; k < 3; k++) rd_check(k, "R8");

    // R2/R6 random batches
    for (int it = 0; it < 6; it++) begin
      int len, base;
      bit acc;
      rand_tile(); load_tile(); adopt_tile(); @(negedge clk);
      len  = 1 + int'($urandom % 10);
      base = int'($urandom % DEPTH);
      acc  = 1'($urandom);
      rand_rows(len);
      run_batch(len, base, acc, (it % 2) ? 25 : 0);
      for (int k = 0; k < len; k++) rd_check((base + k) % DEPTH, acc ? "R6" : "R2");
    end

    report();
    $finish;
  end
endmodule